// File: doc/BRIEF.md
# Debounced Multi-Pin Wakeup Detector

This block watches eight wakeup pins that arrive without any timing relation to its slow (about 32 kHz) clock. Each pin first passes through a synchroniser. It then goes to a qualifier of its own, which checks for the pin's active level and for how long the pin has held that level. When an enabled pin qualifies, the block latches a sticky cause bit for that pin. A single wakeup request is raised for as long as any cause bit is held.

One debounce code is shared by all pins and sets the qualification time. The mapping from code to time is deliberately non-linear, so it covers a range from a few clock periods to about one second. Code zero, and every code the mapping does not define, removes the time requirement, and a pin then qualifies on level alone.

Software uses a small register port. It writes the debounce code, the per-pin polarity and the per-pin enable. It reads the cause bits and clears them by writing ones. The request is released once software has cleared every cause.

Top module: `wake_debounce_top`

## Requirements
- R1: After a synchronous reset, the debounce code, polarity, enable and cause registers are all zero, `wake_req` is low and `reg_rdata` reads zero.
- R2: The registers are at these `reg_addr` values: 0 is the debounce code (bits 4:0), 1 is polarity (bits 7:0), 2 is enable (bits 7:0) and 3 is cause (bits 15:0). `reg_rdata` returns the register addressed at the previous clock edge, and any bit above a field's width reads zero.
- R3: A polarity bit of 1 makes its pin active when high. A polarity bit of 0 makes it active when low.
- R4: Each pin passes through two flip-flops before its level is judged. With code 0, a pin that becomes active just before edge k sets its cause bit, and raises `wake_req`, at edge k+2.
- R5: Codes 1, 2, 3, 4, 5 and 6 require N = 2, 3, 32, 512, 4096 and 32768 consecutive active synchronised samples. A pin that becomes active before edge k sets its cause at edge k+N+1.
- R6: Any synchronised sample at the inactive level restarts that pin's count. A series of active runs, each shorter than N, sets nothing.
- R7: Codes 7 to 31 behave exactly as code 0.
- R8: A pin whose enable bit is 0 never sets its cause bit, however long it stays active.
- R9: Cause bits are sticky. Writing 1 to a bit at address 3 clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: `wake_req` is high exactly when at least one cause bit is set.
- R11: Each pin qualifies independently. Several pins can hold cause bits at the same time, each bit at its own pin's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wake_pins | input | 8 | Asynchronous wakeup pins |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select (0 code, 1 polarity, 2 enable, 3 cause) |
| reg_wdata | input | 16 | Write data; at address 3, each 1 clears a cause bit |
| reg_rdata | output | 16 | Registered read data for the register addressed at the last edge |
| wake_req | output | 1 | High while any cause bit is set |

## Verification
A run counter that restarts at the wrong time, or a wrong threshold, appears at the ports as a shift in the edge at which `wake_req` rises. The shift equals the counting error, so measuring the rise edge exactly against N+2 exposes any off-by-one. A lost or stray cause bit shows up on `wake_req` and on a cause read in the very next cycle. The reference model compares both outputs on every clock. The edge counts are measured directly for each debounce code, for the glitch-restart case and for clear-versus-set collisions.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    WK_ADDR_DEB   = 2'd0,
    WK_ADDR_POL   = 2'd1,
    WK_ADDR_EN    = 2'd2,
    WK_ADDR_CAUSE = 2'd3
  } wk_addr_e;

  localparam int WK_THR_W = 16;

  // Number of consecutive active samples needed for a given debounce code.
  // Undefined codes fall back to level sensitivity (one sample).
  function automatic logic [WK_THR_W-1:0] wk_threshold(input logic [4:0] code);
    logic [WK_THR_W-1:0] thr;
    case (code)
      5'd1:    thr = 16'd2;
      5'd2:    thr = 16'd3;
      5'd3:    thr = 16'd32;
      5'd4:    thr = 16'd512;
      5'd5:    thr = 16'd4096;
      5'd6:    thr = 16'd32768;
      default: thr = 16'd1;
    endcase
    return thr;
  endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wk_qualifier.sv
module wk_qualifier
  import wk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_sync,
  input  logic             pol_high,
  input  logic [CFG_W-1:0] deb_code,
  output logic             qual
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] thr;
  logic             active;

  assign active  = (pin_sync == pol_high);
  assign run_len = (run_q == CNT_MAX) ? CNT_MAX : run_q + 1'b1;
  assign thr     = CNT_W'(wk_threshold(5'(deb_code)));
  assign qual    = active && (run_len >= thr);

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (active) run_q <= run_len;
    else             run_q <= '0;
  end
endmodule

// File: rtl/wk_regfile.sv
module wk_regfile
  import wk_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CFG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [NUM_PINS-1:0] qual_vec,
  output logic [CFG_W-1:0]    deb_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic [DATA_W-1:0]   cause_q,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                wake_req
);
  wk_addr_e           sel;
  logic [DATA_W-1:0]  clr_mask;
  logic [DATA_W-1:0]  set_mask;
  logic [DATA_W-1:0]  cause_d;
  logic [DATA_W-1:0]  rd_d;

  assign sel      = wk_addr_e'(reg_addr);
  assign clr_mask = (reg_wr && sel == WK_ADDR_CAUSE) ? reg_wdata : '0;
  assign set_mask = DATA_W'(qual_vec & en_q);
  assign cause_d  = (cause_q & ~clr_mask) | set_mask;

  always_comb begin
    case (sel)
      WK_ADDR_DEB: rd_d = DATA_W'(deb_q);
      WK_ADDR_POL: rd_d = DATA_W'(pol_q);
      WK_ADDR_EN:  rd_d = DATA_W'(en_q);
      default:     rd_d = cause_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deb_q     <= '0;
      pol_q     <= '0;
      en_q      <= '0;
      cause_q   <= '0;
      reg_rdata <= '0;
      wake_req  <= 1'b0;
    end else begin
      if (reg_wr && sel == WK_ADDR_DEB) deb_q <= reg_wdata[CFG_W-1:0];
      if (reg_wr && sel == WK_ADDR_POL) pol_q <= reg_wdata[NUM_PINS-1:0];
      if (reg_wr && sel == WK_ADDR_EN)  en_q  <= reg_wdata[NUM_PINS-1:0];
      cause_q   <= cause_d;
      reg_rdata <= rd_d;
      wake_req  <= |cause_d;
    end
  end
endmodule

// File: rtl/wake_debounce_top.sv
module wake_debounce_top #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int CFG_W       = 5,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] wake_pins,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                wake_req
);
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] qual_vec;
  logic [CFG_W-1:0]    deb_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] en_q;
  logic [DATA_W-1:0]   cause_q;

  wk_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (wake_pins),
    .dout(pins_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    wk_qualifier #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .pin_sync(pins_sync[p]),
      .pol_high(pol_q[p]),
      .deb_code(deb_q),
      .qual    (qual_vec[p])
    );
  end

  wk_regfile #(
    .NUM_PINS(NUM_PINS), .CFG_W(CFG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .qual_vec (qual_vec),
    .deb_q    (deb_q),
    .pol_q    (pol_q),
    .en_q     (en_q),
    .cause_q  (cause_q),
    .reg_rdata(reg_rdata),
    .wake_req (wake_req)
  );
endmodule

// File: rtl/wk_checker.sv
module wk_checker #(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] qual_vec,
  input logic [DATA_W-1:0]   cause_q,
  input logic                wake_req
);
  logic [DATA_W-1:0] pin_bits;
  assign pin_bits = DATA_W'({NUM_PINS{1'b1}});

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && !wake_req)); // R1

  AST_REQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    wake_req == (cause_q != '0)); // R10

  AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~$past(cause_q) & ~DATA_W'($past(en_q))) == '0)); // R8

  AST_SET_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~$past(cause_q) & ~DATA_W'($past(qual_vec))) == '0)); // R5

  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (($past(cause_q) & ~cause_q &
      ~(($past(reg_wr) && $past(reg_addr) == ADDR_W'(3)) ? $past(reg_wdata) : '0)) == '0)); // R9

  AST_UPPER_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~pin_bits) == '0)); // R11
endmodule

bind wake_debounce_top wk_checker #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .en_q     (en_q),
  .qual_vec (qual_vec),
  .cause_q  (cause_q),
  .wake_req (wake_req)
);

// File: tb/wake_debounce_top_tb_top.sv
module wake_debounce_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  wake_pins = 8'h00;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        wake_req;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #5 clk = ~clk;

  wake_debounce_top dut_i (
    .clk(clk), .rst(rst), .wake_pins(wake_pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_req(wake_req)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0]  m_s1, m_s2, m_pol, m_en;
  bit [4:0]  m_code;
  bit [15:0] m_cause, m_rd;
  bit        m_wake;
  int        m_run [8];

  function automatic int need_samples(input bit [4:0] code);
    int t;
    t = 1;
    if (code == 1) t = 2;
    if (code == 2) t = 3;
    if (code == 3) t = 32;
    if (code == 4) t = 512;
    if (code == 5) t = 4096;
    if (code == 6) t = 32768;
    return t;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_pol = 0; m_en = 0; m_code = 0;
      m_cause = 0; m_rd = 0; m_wake = 0;
      foreach (m_run[i]) m_run[i] = 0;
    end else begin
      bit [15:0] nxt;
      bit [15:0] clr;
      nxt = m_cause;
      clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata : 16'h0;
      nxt = nxt & ~clr;
      for (int i = 0; i < 8; i++) begin
        bit act;
        act = (m_s2[i] == m_pol[i]);
        if (act) begin
          if (m_run[i] < 65535) m_run[i] = m_run[i] + 1;
          if (m_en[i] && m_run[i] >= need_samples(m_code)) nxt[i] = 1'b1;
        end else begin
          m_run[i] = 0;
        end
      end
      case (reg_addr)
        2'd0: m_rd = {11'h0, m_code};
        2'd1: m_rd = {8'h0, m_pol};
        2'd2: m_rd = {8'h0, m_en};
        default: m_rd = m_cause;
      endcase
      if (reg_wr && reg_addr == 2'd0) m_code = reg_wdata[4:0];
      if (reg_wr && reg_addr == 2'd1) m_pol  = reg_wdata[7:0];
      if (reg_wr && reg_addr == 2'd2) m_en   = reg_wdata[7:0];
      m_cause = nxt;
      m_wake  = (nxt != 0);
      m_s2 = m_s1;
      m_s1 = wake_pins;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(wake_req == m_wake, cur_req, "wake_req vs model", wake_req, m_wake);
      check(reg_rdata == m_rd, cur_req, "rdata vs model", reg_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit [1:0] a, input bit [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise pins now; expect wake_req low one negedge before edge exp, high at it
  task automatic expect_rise(input bit [7:0] pins, input int exp, input string req);
    wake_pins = pins;
    for (int k = 1; k <= exp; k++) begin
      @(negedge clk);
      if (k == exp - 1) check(wake_req == 1'b0, req, "early wake", wake_req, 0);
      if (k == exp)     check(wake_req == 1'b1, req, "wake edge", wake_req, 1);
    end
  endtask

  task automatic quiet_and_clear(input bit [7:0] idle_pins);
    wake_pins = idle_pins;
    idle(4);
    wr(2'd3, 16'hFFFF);
    idle(1);
    check(wake_req == 1'b0, "R9", "cleared", wake_req, 0);
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000", wd);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    bit [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    check(wake_req == 1'b0, "R1", "reset wake", wake_req, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 16'h0, "R1", "reset reg", d, 0);
    end

    cur_req = "R2";
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check(d == 16'h001F, "R2", "code width", d, 16'h1F);
    wr(2'd1, 16'hFFA5); rd(2'd1, d); check(d == 16'h00A5, "R2", "pol width", d, 16'hA5);
    wr(2'd2, 16'h0000); rd(2'd2, d); check(d == 16'h0000, "R2", "en", d, 0);
    wr(2'd1, 16'h00FF); wr(2'd0, 16'h0000);
    idle(4);

    // R4 / R3 active high, code 0: three edges
    cur_req = "R4";
    wr(2'd2, 16'h0001);
    expect_rise(8'h01, 3, "R4");
    rd(2'd3, d); check(d == 16'h0001, "R4", "cause bit0", d, 1);
    quiet_and_clear(8'h00);

    // R3 active low: pin1 low with polarity 0 qualifies once enabled
    cur_req = "R3";
    wr(2'd1, 16'h00FD);
    wr(2'd2, 16'h0002);
    idle(1);
    check(wake_req == 1'b1, "R3", "active low", wake_req, 1);
    rd(2'd3, d); check(d == 16'h0002, "R3", "cause bit1", d, 2);
    wr(2'd2, 16'h0000);
    quiet_and_clear(8'h00);
    wr(2'd1, 16'h00FF);

    // R5: every defined code on pin2
    cur_req = "R5";
    wr(2'd2, 16'h0004);
    for (int c = 1; c <= 6; c++) begin
      wr(2'd0, 16'(c));
      idle(3);
      expect_rise(8'h04, need_samples(5'(c)) + 2, "R5");
      quiet_and_clear(8'h00);
    end

    // R6: runs of 20 broken by a one-cycle drop under code 3 (32)
    cur_req = "R6";
    wr(2'd0, 16'd3);
    idle(3);
    for (int r = 0; r < 3; r++) begin
      wake_pins = 8'h04; idle(20);
      wake_pins = 8'h00; idle(1);
    end
    idle(3);
    check(wake_req == 1'b0, "R6", "glitchy runs", wake_req, 0);
    expect_rise(8'h04, 34, "R6");
    quiet_and_clear(8'h00);

    // R7: code 9 acts like code 0
    cur_req = "R7";
    wr(2'd0, 16'd9);
    idle(3);
    expect_rise(8'h04, 3, "R7");
    quiet_and_clear(8'h00);
    wr(2'd0, 16'd31);
    idle(3);
    expect_rise(8'h04, 3, "R7");
    quiet_and_clear(8'h00);

    // R8: disabled pins never set
    cur_req = "R8";
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0004);
    wake_pins = 8'hFB;
    idle(40);
    check(wake_req == 1'b0, "R8", "disabled pins", wake_req, 0);
    rd(2'd3, d); check(d == 16'h0, "R8", "cause", d, 0);
    wake_pins = 8'h00; idle(4);

    // R9: sticky, write 0 keeps, write 1 clears, set beats clear
    cur_req = "R9";
    wr(2'd2, 16'h0009);
    wake_pins = 8'h09; idle(4);
    wake_pins = 8'h00; idle(4);
    wr(2'd3, 16'h0000);
    rd(2'd3, d); check(d == 16'h0009, "R9", "write 0 keeps", d, 9);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); check(d == 16'h0008, "R9", "write 1 clears", d, 8);
    wake_pins = 8'h08; idle(4);
    wr(2'd3, 16'h0008);
    rd(2'd3, d); check(d == 16'h0008, "R9", "set wins", d, 8);
    check(wake_req == 1'b1, "R10", "req with cause", wake_req, 1);
    quiet_and_clear(8'h00);
    cur_req = "R10";
    check(wake_req == 1'b0, "R10", "req after clear", wake_req, 0);

    // R11: two pins, staggered, distinct bits
    cur_req = "R11";
    wr(2'd0, 16'd2);
    wr(2'd2, 16'h0030);
    idle(3);
    wake_pins = 8'h10; idle(2);
    wake_pins = 8'h30; idle(3);
    rd(2'd3, d); check(d == 16'h0010, "R11", "first pin only", d, 16'h10);
    idle(3);
    rd(2'd3, d); check(d == 16'h0030, "R11", "both pins", d, 16'h30);
    quiet_and_clear(8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule